// File: doc/BRIEF.md
# Station Address Filter with Loadable Match Table

This block decides, one cycle after a destination-address strobe, whether a received Ethernet frame is kept. It applies three mode switches in a fixed priority order (promiscuous unicast, accept every group address, accept broadcast). If none of them takes the frame, it compares the 48-bit destination against a table of sixteen station addresses, each gated by its own bit in an enable mask. An accepted frame may carry a multicast or a broadcast tag.

The table is filled by a load sequence. A start pulse gives an entry count and a word pointer. The block then requests 16-bit words one at a time, three per entry, followed by one final word that becomes the enable mask. The mask is cleared by reset, so until a load completes only the mode switches can accept frames. While the surrounding device is held in its reset state, the host can read any entry back sixteen bits at a time.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset, acc_valid, acc_ok, acc_mcast, acc_bcast, load_busy, word_req and load_done are low, and the enable mask is zero. With all modes off, every destination (including all zeros, which matches the cleared table contents) is rejected.
- R2: For every cycle with dst_valid high, acc_valid is high exactly one clock later, with the verdict for that address. Back-to-back strobes give back-to-back verdicts.
- R3: With mode_promisc set, a destination whose first byte (dst_addr[7:0]) has bit 0 clear is accepted with no tag. Promiscuous mode alone does not accept a destination with that bit set.
- R4: With mode_all_mcast set, any destination with dst_addr[0] set is accepted and tagged multicast. This check is made before the broadcast check, so an all-ones destination is then tagged multicast, not broadcast.
- R5: With mode_bcast set (and the earlier checks not taking the frame), the all-ones destination is accepted and tagged broadcast. With mode_bcast clear, it is rejected unless it is matched in the table.
- R6: Otherwise, a destination equal to an entry whose enable bit is set is accepted with no tag. Entries with a clear enable bit never match. Anything else is rejected (acc_ok low, no tags).
- R7: A load started with count N takes 3·N words for the entries, filling entries 0 to N-1 in turn. In the word for slice s (s = 0, 1, 2), the low byte becomes address byte 2s and the high byte becomes byte 2s+1. Address byte k is dst_addr[8k+7:8k]. word_addr starts at load_base and advances by one for each word consumed.
- R8: After the entry words, one more word is taken as the enable mask, where bit i enables entry i. A count of zero loads only the mask and leaves the entries unchanged.
- R9: The edge that consumes the mask word clears load_busy and word_req and raises load_done, which stays high for exactly one cycle.
- R10: While dev_in_reset is high, rd_data holds {byte 2s+1, byte 2s} of entry rd_entry for slice s = rd_slice (0 to 2). Slice 3, or dev_in_reset low, gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte k at bits 8k+7:8k |
| mode_promisc | input | 1 | Accept individual (bit 0 clear) addresses |
| mode_all_mcast | input | 1 | Accept all group addresses |
| mode_bcast | input | 1 | Accept the all-ones address |
| acc_valid | output | 1 | Verdict valid, one cycle after dst_valid |
| acc_ok | output | 1 | Frame accepted |
| acc_mcast | output | 1 | Accepted as multicast |
| acc_bcast | output | 1 | Accepted as broadcast |
| load_start | input | 1 | Start a table load (ignored while busy) |
| load_count | input | 5 | Number of entries to load |
| load_base | input | 16 | First word pointer |
| load_busy | output | 1 | Load in progress |
| word_req | output | 1 | Word wanted from the word source |
| word_addr | output | 16 | Pointer of the word wanted |
| word_valid | input | 1 | Word present on word_data |
| word_data | input | 16 | Supplied word |
| load_done | output | 1 | One-cycle pulse at load completion |
| dev_in_reset | input | 1 | Device reset state, enables readback |
| rd_entry | input | 4 | Readback entry select |
| rd_slice | input | 2 | Readback 16-bit slice select |
| rd_data | output | 16 | Readback data |

## Verification
Destinations are sent under each combination of mode switches that separates one priority level from the next. An all-ones destination with both group modes on shows that the multicast check comes first. A group address under promiscuous mode alone shows that promiscuous mode covers only individual addresses. Table addresses are tried against enabled and disabled entries, and a second, count-zero load moves the enable mask, which shows that the gating follows the mask and not the stored bytes. Readback is tried with the reset state on and off, and with an unused slice, to show the gating and the byte order.

// File: rtl/raf_pkg.sv
package raf_pkg;
   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_ENTRY = 2'd1,
      LD_MASK  = 2'd2
   } ld_state_t;

   typedef struct packed {
      logic ok;
      logic mcast;
      logic bcast;
   } verdict_t;
endpackage

// File: rtl/raf_cam_store.sv
module raf_cam_store #(
   parameter int N_ENT   = 16,
   parameter int N_BYTES = 6,
   parameter int WORD_W  = 16,
   localparam int ADDR_W = N_BYTES * 8,
   localparam int SLICES = ADDR_W / WORD_W,
   localparam int IDX_W  = $clog2(N_ENT),
   localparam int SL_W   = $clog2(SLICES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SL_W-1:0]   wr_slice,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              mask_we,
   input  logic [WORD_W-1:0] mask_word,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              hit,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [SL_W-1:0]   rd_slice,
   output logic [WORD_W-1:0] rd_data
);
   logic [ADDR_W-1:0] ent [N_ENT];
   logic [N_ENT-1:0]  en_mask;
   logic [N_ENT-1:0]  hitv;
   logic [ADDR_W-1:0] rd_ent;

   initial begin
      assert (N_ENT <= WORD_W) else $error("mask word too narrow for entry count");
      assert (ADDR_W % WORD_W == 0) else $error("address width must be whole words");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N_ENT; i++) ent[i] <= '0;
         en_mask <= '0;
      end else begin
         if (wr_en) begin
            for (int s = 0; s < SLICES; s++)
               if (wr_slice == SL_W'(s))
                  ent[wr_idx][s*WORD_W +: WORD_W] <= wr_word;
         end
         if (mask_we) en_mask <= mask_word[N_ENT-1:0];
      end
   end

   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      assign hitv[i] = en_mask[i] && (ent[i] == look_addr);
   end
   assign hit = |hitv;

   assign rd_ent = ent[rd_idx];
   always_comb begin
      rd_data = '0;
      if (rd_en)
         for (int s = 0; s < SLICES; s++)
            if (rd_slice == SL_W'(s)) rd_data = rd_ent[s*WORD_W +: WORD_W];
   end

   // R6
   disabled_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (en_mask == '0) |-> !hit);
endmodule

// File: rtl/raf_cam_loader.sv
module raf_cam_loader
   import raf_pkg::*;
#(
   parameter int N_ENT  = 16,
   parameter int CNT_W  = 5,
   parameter int PTR_W  = 16,
   parameter int SLICES = 3,
   localparam int IDX_W = $clog2(N_ENT),
   localparam int SL_W  = $clog2(SLICES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] count,
   input  logic [PTR_W-1:0] base,
   input  logic             word_valid,
   output logic             busy,
   output logic             word_req,
   output logic [PTR_W-1:0] word_addr,
   output logic             cam_we,
   output logic [IDX_W-1:0] cam_idx,
   output logic [SL_W-1:0]  cam_slice,
   output logic             mask_we,
   output logic             done
);
   ld_state_t        state;
   logic [CNT_W-1:0] left;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= LD_IDLE;
         left      <= '0;
         word_addr <= '0;
         cam_idx   <= '0;
         cam_slice <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            LD_IDLE: if (start) begin
               word_addr <= base;
               cam_idx   <= '0;
               cam_slice <= '0;
               left      <= count;
               state     <= (count == '0) ? LD_MASK : LD_ENTRY;
            end
            LD_ENTRY: if (word_valid) begin
               word_addr <= word_addr + 1'b1;
               if (cam_slice == SL_W'(SLICES - 1)) begin
                  cam_slice <= '0;
                  cam_idx   <= cam_idx + 1'b1;
                  left      <= left - 1'b1;
                  if (left == CNT_W'(1)) state <= LD_MASK;
               end else begin
                  cam_slice <= cam_slice + 1'b1;
               end
            end
            LD_MASK: if (word_valid) begin
               word_addr <= word_addr + 1'b1;
               state     <= LD_IDLE;
               done      <= 1'b1;
            end
            default: state <= LD_IDLE;
         endcase
      end
   end

   assign busy     = (state != LD_IDLE);
   assign word_req = busy;
   assign cam_we   = (state == LD_ENTRY) && word_valid;
   assign mask_we  = (state == LD_MASK) && word_valid;

   // R7
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && word_valid) |=> (word_addr == $past(word_addr) + 1'b1));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
endmodule

// File: rtl/raf_decide.sv
module raf_decide
   import raf_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dst_valid,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic              m_promisc,
   input  logic              m_all_mcast,
   input  logic              m_bcast,
   input  logic              cam_hit,
   output logic              acc_valid,
   output verdict_t          verdict
);
   verdict_t nxt;
   logic     group_bit;
   logic     all_ones;

   assign group_bit = dst_addr[0];
   assign all_ones  = &dst_addr;

   always_comb begin
      nxt = '0;
      if (m_promisc && !group_bit)       nxt.ok = 1'b1;
      else if (m_all_mcast && group_bit) begin nxt.ok = 1'b1; nxt.mcast = 1'b1; end
      else if (m_bcast && all_ones)      begin nxt.ok = 1'b1; nxt.bcast = 1'b1; end
      else if (cam_hit)                  nxt.ok = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_valid <= 1'b0;
         verdict   <= '0;
      end else begin
         acc_valid <= dst_valid;
         verdict   <= dst_valid ? nxt : '0;
      end
   end

   // R2
   strobe_lat_chk: assert property (@(posedge clk) disable iff (rst)
      dst_valid |=> acc_valid);
   // R4
   tag_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(verdict.mcast && verdict.bcast));
   // R5
   tag_ok_chk: assert property (@(posedge clk) disable iff (rst)
      (verdict.mcast || verdict.bcast) |-> (verdict.ok && acc_valid));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import raf_pkg::*;
#(
   parameter int N_ENT   = 16,
   parameter int N_BYTES = 6,
   parameter int WORD_W  = 16,
   parameter int CNT_W   = 5,
   parameter int PTR_W   = 16,
   localparam int ADDR_W = N_BYTES * 8,
   localparam int SLICES = ADDR_W / WORD_W,
   localparam int IDX_W  = $clog2(N_ENT),
   localparam int SL_W   = $clog2(SLICES + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dst_valid,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic              mode_promisc,
   input  logic              mode_all_mcast,
   input  logic              mode_bcast,
   output logic              acc_valid,
   output logic              acc_ok,
   output logic              acc_mcast,
   output logic              acc_bcast,
   input  logic              load_start,
   input  logic [CNT_W-1:0]  load_count,
   input  logic [PTR_W-1:0]  load_base,
   output logic              load_busy,
   output logic              word_req,
   output logic [PTR_W-1:0]  word_addr,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word_data,
   output logic              load_done,
   input  logic              dev_in_reset,
   input  logic [IDX_W-1:0]  rd_entry,
   input  logic [SL_W-1:0]   rd_slice,
   output logic [WORD_W-1:0] rd_data
);
   logic             cam_we, mask_we, cam_hit;
   logic [IDX_W-1:0] cam_idx;
   logic [SL_W-1:0]  cam_slice;
   verdict_t         verdict;

   raf_cam_loader #(.N_ENT(N_ENT), .CNT_W(CNT_W), .PTR_W(PTR_W), .SLICES(SLICES)) u_loader (
      .clk(clk), .rst(rst), .start(load_start), .count(load_count), .base(load_base),
      .word_valid(word_valid), .busy(load_busy), .word_req(word_req), .word_addr(word_addr),
      .cam_we(cam_we), .cam_idx(cam_idx), .cam_slice(cam_slice), .mask_we(mask_we),
      .done(load_done));

   raf_cam_store #(.N_ENT(N_ENT), .N_BYTES(N_BYTES), .WORD_W(WORD_W)) u_store (
      .clk(clk), .rst(rst), .wr_en(cam_we), .wr_idx(cam_idx), .wr_slice(cam_slice),
      .wr_word(word_data), .mask_we(mask_we), .mask_word(word_data),
      .look_addr(dst_addr), .hit(cam_hit), .rd_en(dev_in_reset), .rd_idx(rd_entry),
      .rd_slice(rd_slice), .rd_data(rd_data));

   raf_decide #(.ADDR_W(ADDR_W)) u_decide (
      .clk(clk), .rst(rst), .dst_valid(dst_valid), .dst_addr(dst_addr),
      .m_promisc(mode_promisc), .m_all_mcast(mode_all_mcast), .m_bcast(mode_bcast),
      .cam_hit(cam_hit), .acc_valid(acc_valid), .verdict(verdict));

   assign acc_ok    = verdict.ok;
   assign acc_mcast = verdict.mcast;
   assign acc_bcast = verdict.bcast;

   // R10
   rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !dev_in_reset |-> (rd_data == '0));
   // R9
   req_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (load_start && !load_busy) |=> load_busy);
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        dst_valid = 1'b0;
   logic [47:0] dst_addr = '0;
   logic        mode_promisc = 1'b0, mode_all_mcast = 1'b0, mode_bcast = 1'b0;
   logic        acc_valid, acc_ok, acc_mcast, acc_bcast;
   logic        load_start = 1'b0;
   logic [4:0]  load_count = '0;
   logic [15:0] load_base = '0;
   logic        load_busy, word_req, word_valid = 1'b0, load_done;
   logic [15:0] word_addr, word_data = '0, rd_data;
   logic        dev_in_reset = 1'b0;
   logic [3:0]  rd_entry = '0;
   logic [1:0]  rd_slice = '0;

   int tests = 0, fails = 0;
   logic [47:0] tb_cam [16];
   logic [15:0] tb_mask = '0;
   logic [2:0]  expq [$];
   string       reqq [$];
   logic [15:0] wq [$];

   always #4 clk = ~clk;

   rx_addr_filter i_rx_addr_filter (
      .clk(clk), .rst(rst), .dst_valid(dst_valid), .dst_addr(dst_addr),
      .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast), .mode_bcast(mode_bcast),
      .acc_valid(acc_valid), .acc_ok(acc_ok), .acc_mcast(acc_mcast), .acc_bcast(acc_bcast),
      .load_start(load_start), .load_count(load_count), .load_base(load_base),
      .load_busy(load_busy), .word_req(word_req), .word_addr(word_addr),
      .word_valid(word_valid), .word_data(word_data), .load_done(load_done),
      .dev_in_reset(dev_in_reset), .rd_entry(rd_entry), .rd_slice(rd_slice), .rd_data(rd_data));

   task automatic chk(input logic ok, input string req, input logic [47:0] act, input logic [47:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected verdict {ok,mcast,bcast} from the requirements
   function automatic logic [2:0] model(input logic [47:0] a);
      if (mode_promisc && !a[0]) return 3'b100;
      if (mode_all_mcast && a[0]) return 3'b110;
      if (mode_bcast && (&a)) return 3'b101;
      for (int i = 0; i < 16; i++) if (tb_mask[i] && tb_cam[i] == a) return 3'b100;
      return 3'b000;
   endfunction

   // Driver: one strobe per call, expected verdict into the scoreboard
   task automatic send(input logic [47:0] a, input string req);
      @(negedge clk);
      dst_valid = 1'b1;
      dst_addr  = a;
      expq.push_back(model(a));
      reqq.push_back(req);
      @(negedge clk);
      dst_valid = 1'b0;
   endtask

   // Monitor
   always @(negedge clk) begin
      if (!rst && acc_valid) begin
         if (expq.size() == 0) chk(1'b0, "R2", 48'(1), 48'(0));
         else begin
            logic [2:0] e;
            string r;
            e = expq.pop_front();
            r = reqq.pop_front();
            chk({acc_ok, acc_mcast, acc_bcast} == e, r, 48'({acc_ok, acc_mcast, acc_bcast}), 48'(e));
         end
      end
   end

   task automatic load(input logic [15:0] base, input int cnt, input logic [15:0] mask);
      wq.delete();
      for (int e = 0; e < cnt; e++)
         for (int s = 0; s < 3; s++) wq.push_back(tb_cam[e][16*s +: 16]);
      wq.push_back(mask);
      @(negedge clk);
      load_start = 1'b1; load_count = 5'(cnt); load_base = base;
      @(negedge clk);
      load_start = 1'b0;
      for (int k = 0; k < wq.size(); k++) begin
         chk(load_busy && word_req, "R7", 48'(load_busy), 48'(1));
         chk(word_addr == base + 16'(k), "R7", 48'(word_addr), 48'(base + 16'(k)));
         word_valid = 1'b1;
         word_data  = wq[k];
         @(negedge clk);
      end
      word_valid = 1'b0;
      chk(load_done && !load_busy && !word_req, "R9", 48'({load_done, load_busy}), 48'(2'b10));
      tb_mask = mask;
      @(negedge clk);
      chk(!load_done, "R9", 48'(load_done), 48'(0));
   endtask

   task automatic readback(input logic inr, input int e, input int s, input logic [15:0] exp);
      @(negedge clk);
      dev_in_reset = inr; rd_entry = 4'(e); rd_slice = 2'(s);
      #1 chk(rd_data == exp, "R10", 48'(rd_data), 48'(exp));
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) tb_cam[i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(!acc_valid && !acc_ok && !acc_mcast && !acc_bcast && !load_busy && !word_req && !load_done,
          "R1", 48'({acc_valid, acc_ok, load_busy, load_done}), 48'(0));
      send(48'h0, "R1");            // zero entries disabled by cleared mask
      send(48'h665544332211, "R1");

      // R7/R8/R9 load three entries, entry 1 disabled
      tb_cam[0] = 48'h665544332211;
      tb_cam[1] = 48'h0A0B0C0D0E02;
      tb_cam[2] = 48'hFFEEDDCCBBAA;
      load(16'h0100, 3, 16'h0005);

      // R10 readback byte order and gating
      readback(1'b1, 0, 1, 16'h4433);
      readback(1'b1, 2, 2, 16'hFFEE);
      readback(1'b1, 1, 0, 16'h0E02);
      readback(1'b1, 0, 3, 16'h0000);
      readback(1'b0, 0, 0, 16'h0000);
      @(negedge clk); dev_in_reset = 1'b0;

      // R6 table hits, disabled entry, miss; R2 back-to-back
      @(negedge clk);
      dst_valid = 1'b1; dst_addr = 48'h665544332211; expq.push_back(model(dst_addr)); reqq.push_back("R6");
      @(negedge clk);
      dst_addr = 48'h0A0B0C0D0E02; expq.push_back(model(dst_addr)); reqq.push_back("R6");
      @(negedge clk);
      dst_addr = 48'hFFEEDDCCBBAA; expq.push_back(model(dst_addr)); reqq.push_back("R2");
      @(negedge clk);
      dst_valid = 1'b0;
      send(48'h123456789A02, "R6");
      send(48'hFFFFFFFFFFFF, "R5");  // broadcast off: rejected

      // R5 broadcast tag
      mode_bcast = 1'b1;
      send(48'hFFFFFFFFFFFF, "R5");
      send(48'h000000000003, "R5");
      // R4 multicast wins over broadcast
      mode_all_mcast = 1'b1;
      send(48'hFFFFFFFFFFFF, "R4");
      send(48'h998877665501, "R4");
      mode_all_mcast = 1'b0; mode_bcast = 1'b0;
      // R3 promiscuous
      mode_promisc = 1'b1;
      send(48'h123456789A02, "R3");
      send(48'h123456789A03, "R3");
      mode_promisc = 1'b0;

      // R8 count zero: only the mask moves
      load(16'h0200, 0, 16'h0002);
      send(48'h0A0B0C0D0E02, "R8");
      send(48'h665544332211, "R8");
      readback(1'b1, 0, 0, 16'h2211);
      @(negedge clk); dev_in_reset = 1'b0;

      repeat (4) @(negedge clk);
      chk(expq.size() == 0, "R2", 48'(expq.size()), 48'(0));
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule